// File: doc/BRIEF.md
# Asynchronous Serial Frame Receiver with Parity Check

This block turns a single idle-high serial line into characters. A frame is a low start bit, then 5 to 9 data bits with the least significant bit first, then an optional parity bit, then a high stop bit. The caller supplies a free-running `baud_tick` strobe that fires `OVS` times per bit period. The receiver counts these strobes to take one sample near the middle of every bit. It does not vote across several samples.

Each finished character appears on `rx_data`, right-aligned, with the ninth bit on `rx_bit8`. A one-cycle `rx_valid` pulse marks it. The parity-error and framing-error flags belong to the same character and change in the same cycle. The character length and the parity mode are captured when the start edge is seen, so the host may change them between frames. There is no stop-bit-count input: the receiver checks exactly one stop bit, so a sender that uses one or two stop bits is received the same way.

Top module: `async_frame_rx`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first character, `rx_valid`, `parity_err`, `frame_err`, `rx_bit8` and `rx_data` are all 0.
- R2: A falling edge on the (synchronised) line while idle starts a frame. With `baud_tick` pulsing `OVS` times per bit, the start bit is sampled `OVS/2` ticks after the edge, and every later bit `OVS` ticks after the one before it. `rx_valid` is a single-cycle pulse, raised one clock after the stop-bit sample, inside the stop bit.
- R3: `len_sel` picks the data length: 0→5, 1→6, 2→7, 3→8 bits, and any value 4 to 7 gives 9 bits. Data bits are received LSB first and presented right-aligned on {`rx_bit8`,`rx_data`}. Every bit above the length is 0. `len_sel` and `par_mode` are captured at the start edge.
- R4: For 9-bit characters the last data bit appears on `rx_bit8`. For shorter characters `rx_bit8` is 0.
- R5: `par_mode` 2'b00 and the unused code 2'b01 expect no parity bit and always give `parity_err`=0. 2'b10 (even) flags an error when the data bits (the ninth included) plus the parity bit hold an odd number of ones. 2'b11 (odd) flags an error when that number is even.
- R6: Exactly one stop bit is checked. If it is sampled low, `frame_err`=1; if high, `frame_err`=0. A new start bit may follow the single stop bit at once and is received.
- R7: If the line is high again at the start-bit sample point, the edge is treated as a glitch: the receiver returns to idle and no `rx_valid` is produced.
- R8: `rx_data`, `rx_bit8`, `parity_err` and `frame_err` change only together with `rx_valid`, and they hold their values until the next character.
- R9: `rx_in` passes through two flip-flops before any use. A line that stays low after a framing error starts no new frame until it has gone high and then low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| baud_tick | input | 1 | Sampling strobe, `OVS` pulses per bit period |
| rx_in | input | 1 | Serial receive line, idle high, asynchronous |
| len_sel | input | 3 | Data length code (R3) |
| par_mode | input | 2 | Parity mode code (R5) |
| rx_data | output | 8 | Received data bits 7..0, right-aligned |
| rx_bit8 | output | 1 | Ninth data bit |
| rx_valid | output | 1 | One-cycle character strobe |
| parity_err | output | 1 | Parity mismatch for the current character |
| frame_err | output | 1 | Stop bit sampled low for the current character |

## Verification
The bench sends characters whose values set bits above the selected length. A receiver that fails to mask or align the data would show those bits in `rx_data` or on `rx_bit8`. Parity frames run in both modes, with the parity bit correct and inverted, and include a ninth bit that flips the parity. A check that drops the ninth bit, swaps even and odd, or expects a parity bit under the unused code would lose alignment with the line or report the wrong flag. Frames are sent back to back with one stop bit and also with a long idle gap, and a stop bit is driven low and held. A receiver that waits for a second stop bit, or that re-triggers on a low level, would miss characters or report extra ones. A short low pulse must produce nothing. Every strobe must fall inside the stop bit, and the held outputs must not change between strobes.

// File: rtl/async_frame_rx.sv
module async_frame_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rx_in,
  input  logic [2:0] len_sel,
  input  logic [1:0] par_mode,
  output logic [7:0] rx_data,
  output logic       rx_bit8,
  output logic       rx_valid,
  output logic       parity_err,
  output logic       frame_err
);
  localparam int HALF = OVS / 2;
  localparam int CW   = (OVS > 2) ? $clog2(OVS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t         st;
  logic [1:0]  sync_q;
  logic        rx_prev;
  logic [CW-1:0] cnt;
  logic [3:0]  bidx, nb_q;
  logic [1:0]  pm_q;
  logic [8:0]  shreg;
  logic        par_acc, perr_q;

  wire        rx_s     = sync_q[1];
  wire [3:0]  nbits_in = (len_sel > 3'd3) ? 4'd9 : 4'd5 + {1'b0, len_sel};
  wire [CW-1:0] lim    = (st == S_START) ? CW'(HALF - 1) : CW'(OVS - 1);
  wire        mid      = baud_tick && (cnt == lim);
  wire [8:0]  aligned  = shreg >> (4'd9 - nb_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      rx_prev <= 1'b1;
    end else begin
      sync_q  <= {sync_q[0], rx_in};
      rx_prev <= rx_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      bidx       <= '0;
      nb_q       <= 4'd8;
      pm_q       <= 2'b00;
      shreg      <= '0;
      par_acc    <= 1'b0;
      perr_q     <= 1'b0;
      rx_data    <= '0;
      rx_bit8    <= 1'b0;
      rx_valid   <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (st != S_IDLE && baud_tick)
        cnt <= mid ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE:
          if (rx_prev && !rx_s) begin
            st      <= S_START;
            cnt     <= '0;
            bidx    <= '0;
            nb_q    <= nbits_in;
            pm_q    <= par_mode;
            par_acc <= 1'b0;
          end
        S_START:
          if (mid) st <= rx_s ? S_IDLE : S_DATA;
        S_DATA:
          if (mid) begin
            shreg   <= {rx_s, shreg[8:1]};
            par_acc <= par_acc ^ rx_s;
            bidx    <= bidx + 4'd1;
            if (bidx == nb_q - 4'd1) st <= pm_q[1] ? S_PAR : S_STOP;
          end
        S_PAR:
          if (mid) begin
            perr_q <= par_acc ^ rx_s ^ pm_q[0];
            st     <= S_STOP;
          end
        S_STOP:
          if (mid) begin
            rx_valid   <= 1'b1;
            frame_err  <= !rx_s;
            parity_err <= pm_q[1] & perr_q;
            rx_bit8    <= aligned[8];
            rx_data    <= aligned[7:0];
            st         <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r6_ferr_line: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (frame_err == !$past(rx_s)));

  a_r5_no_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !pm_q[1]) |-> !parity_err);

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (({rx_bit8, rx_data} >> nb_q) == 9'd0));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data) && $stable(frame_err));
endmodule

// File: tb/async_frame_rx_tb.sv
module async_frame_rx_tb_top;
  localparam int OVS = 16;
  localparam int DIV = 4;
  localparam int BIT = OVS * DIV;

  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, rx_in = 1'b1;
  logic [2:0] len_sel = 3'd3;
  logic [1:0] par_mode = 2'b00;
  logic [7:0] rx_data;
  logic rx_bit8, rx_valid, parity_err, frame_err;

  async_frame_rx #(.OVS(OVS)) dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_in(rx_in),
    .len_sel(len_sel), .par_mode(par_mode), .rx_data(rx_data), .rx_bit8(rx_bit8),
    .rx_valid(rx_valid), .parity_err(parity_err), .frame_err(frame_err));

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, n_valid = 0, dv = 0;
  int q_val[$], q_b8[$], q_pe[$], q_fe[$], q_t0[$];
  logic [9:0] last = '0, prev_out = '0;
  logic [1:0] last_fl = '0, prev_fl = '0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    dv = (dv + 1) % DIV;
    baud_tick <= (dv == 0);
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      n_valid++;
      if (q_val.size() == 0) chk(0, "R2", "unexpected rx_valid", 1, 0);
      else begin
        int v, b8, pe, fe, t0;
        v = q_val.pop_front(); b8 = q_b8.pop_front(); pe = q_pe.pop_front();
        fe = q_fe.pop_front(); t0 = q_t0.pop_front();
        chk(prev_out == last && prev_fl == last_fl, "R8", "outputs changed before strobe",
            int'(prev_out), int'(last));
        chk(rx_data == v[7:0], "R3", "rx_data", rx_data, v[7:0]);
        chk(rx_bit8 == b8[0], "R4", "rx_bit8", rx_bit8, b8);
        chk(parity_err == pe[0], "R5", "parity_err", parity_err, pe);
        chk(frame_err == fe[0], "R6", "frame_err", frame_err, fe);
        chk(cyc > t0 + BIT / 4 && cyc < t0 + BIT, "R2", "strobe cycle vs stop start", cyc - t0, BIT / 2);
        last = {1'b0, rx_bit8, rx_data}; last_fl = {parity_err, frame_err};
      end
    end
    prev_out = {1'b0, rx_bit8, rx_data};
    prev_fl  = {parity_err, frame_err};
  end

  task automatic put_bit(input logic b);
    rx_in = b;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic send(input int lc, input logic [1:0] pm, input int val,
                      input bit flip, input bit stop_b, input int gap);
    int n, m;
    logic p;
    n = (lc > 3) ? 9 : 5 + lc;
    m = val & ((1 << n) - 1);
    len_sel = 3'(lc); par_mode = pm;
    put_bit(1'b0);
    for (int i = 0; i < n; i++) put_bit(m[i]);
    if (pm[1]) begin
      p = (^m[8:0]) ^ pm[0] ^ flip;
      put_bit(p);
    end
    q_val.push_back(m); q_b8.push_back(m[8]); q_pe.push_back(pm[1] & flip);
    q_fe.push_back(!stop_b); q_t0.push_back(cyc);
    put_bit(stop_b);
    rx_in = 1'b1;
    repeat (gap * BIT) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(rx_valid == 0 && rx_data == 0 && rx_bit8 == 0 && parity_err == 0 && frame_err == 0,
        "R1", "outputs in reset", {rx_valid, rx_bit8, parity_err, frame_err}, 0);
    rst_n = 1'b1;
    repeat (BIT) @(negedge clk);
    chk(rx_valid == 0 && rx_data == 0 && frame_err == 0, "R1", "outputs after reset", rx_data, 0);
    send(3, 2'b00, 'hA5, 0, 1, 1);
    send(0, 2'b00, 'hFF, 0, 1, 1);
    send(1, 2'b00, 'h1EA, 0, 1, 1);
    send(2, 2'b00, 'h155, 0, 1, 2);
    send(4, 2'b00, 'h1A5, 0, 1, 1);
    send(7, 2'b00, 'h05A, 0, 1, 1);
    send(3, 2'b10, 'h3C, 0, 1, 1);
    send(3, 2'b10, 'h3D, 1, 1, 1);
    send(3, 2'b11, 'h81, 0, 1, 1);
    send(3, 2'b11, 'h80, 1, 1, 1);
    send(4, 2'b10, 'h100, 0, 1, 1);
    send(4, 2'b11, 'h1FF, 1, 1, 1);
    send(2, 2'b01, 'h7F, 0, 1, 1);
    send(3, 2'b00, 'h11, 0, 1, 0);
    send(3, 2'b10, 'hEE, 0, 1, 0);
    send(0, 2'b11, 'h0A, 0, 1, 2);
    for (int k = 0; k < 10; k++)
      send(k % 5, 2'((k * 3) % 4), (k * 77 + 13) & 'h1FF, k[0], 1, k % 2);
    begin
      int nv;
      nv = n_valid;
      rx_in = 1'b0; repeat (BIT / 4) @(negedge clk); rx_in = 1'b1;
      repeat (3 * BIT) @(negedge clk);
      chk(n_valid == nv, "R7", "strobes after glitch", n_valid - nv, 0);
      send(3, 2'b00, 'hC3, 0, 0, 0);
      rx_in = 1'b0; repeat (3 * BIT) @(negedge clk); rx_in = 1'b1;
      repeat (BIT) @(negedge clk);
      chk(n_valid == nv + 1, "R9", "strobes with line held low", n_valid - nv, 1);
      send(4, 2'b10, 'h0F0, 0, 1, 2);
    end
    chk(q_val.size() == 0, "R2", "characters never strobed", q_val.size(), 0);
    finish_run();
  end

  initial begin
    wait (cyc > 150000);
    chk(0, "R2", "watchdog expired", cyc, 150000);
    finish_run();
  end
endmodule